// File: doc/BRIEF.md
# Processor Cache-Miss Stall Controller

This block decides, cycle by cycle, whether a simple in-order processor core advances. It keeps a run status for the core's single thread. It watches the hit or miss result of each instruction fetch and each data access, and the pulse that reports a miss has been filled. From these it produces an advance enable for the core's pipeline and a fetch-skip indication. It also keeps two saturating counters of stall cycles, one for instruction misses and one for data misses.

The status takes one of six named states, each with a 3-bit code on `state_o`:

- `ST_IDLE` (0): the thread is not running.
- `ST_RUN` (1): the core is fetching and executing.
- `ST_IWAIT` (2): a fetch miss is outstanding.
- `ST_IRESUME` (3): a fetch miss has been filled, and the instruction fetched before the stall is still held.
- `ST_DWAIT` (4): a data miss is outstanding.
- `ST_PARKED` (5): the core has been handed over to another core model.

The named transitions are:

- activate: `ST_IDLE` or `ST_PARKED` to `ST_RUN`.
- suspend: `ST_RUN` to `ST_IDLE`.
- fetch-stall: `ST_RUN` to `ST_IWAIT`.
- data-stall: `ST_RUN` to `ST_DWAIT`.
- fetch-fill: `ST_IWAIT` to `ST_IRESUME`.
- reissue: `ST_IRESUME` to `ST_RUN`.
- data-fill: `ST_DWAIT` to `ST_RUN`.
- park: any state to `ST_PARKED`.

A cache raises a miss that the block acts on only when it also says it will deliver a completion pulse. Otherwise the miss is handled as a hit. In `ST_IRESUME` the core executes the held instruction without fetching it again, and it must not take interrupts in that cycle. A completion pulse that arrives in a state with nothing outstanding sets a sticky error flag. In `ST_PARKED`, late completions are absorbed silently.

Top module: `miss_stall_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (`ST_IDLE`), both stall counters are 0, `err_o` is 0 and `advance_o` is 0.
- R2: In `ST_IDLE`, `act_req` without `swout_req` moves to `ST_RUN` (code 1) at the next edge. `act_req` has no effect in `ST_RUN`, `ST_IWAIT`, `ST_IRESUME` or `ST_DWAIT`.
- R3: In `ST_RUN`, `susp_req` without `swout_req` moves to `ST_IDLE`. `susp_req` has no effect in any other state.
- R4: `swout_req` moves every state to `ST_PARKED` (code 5) and takes priority over all other inputs. In `ST_PARKED`, `act_req` without `swout_req` moves to `ST_RUN`.
- R5: In `ST_RUN`, with `tick_en` high and neither `susp_req` nor `swout_req`, a fetch miss that is honoured moves to `ST_IWAIT` (code 2). A fetch miss is honoured when `ic_miss` and `ic_evt` are both high. `advance_o` is 0 in that cycle.
- R6: Under the same conditions as R5 but with no honoured fetch miss, a data miss that is honoured moves to `ST_DWAIT` (code 4). A data miss is honoured when `dc_miss` and `dc_evt` are both high. `advance_o` stays 1 in that cycle.
- R7: A miss whose event flag (`ic_evt` or `dc_evt`) is low is handled as a hit: the state stays `ST_RUN` and `advance_o` is 1.
- R8: A `done_pulse` in `ST_IWAIT` without `swout_req` adds the stall length to `istall_o` and moves to `ST_IRESUME` (code 3). The stall length is the number of cycles spent in `ST_IWAIT`, counting the cycle of the pulse.
- R9: In `ST_IRESUME`, `fetch_skip_o` is 1; it also tells the core not to sample interrupts. With `tick_en` high and no `swout_req`, `advance_o` is 1 and the state returns to `ST_RUN`. `fetch_skip_o` is 0 in every other state.
- R10: A `done_pulse` in `ST_DWAIT` without `swout_req` adds the stall length, counted as in R8, to `dstall_o` and moves to `ST_RUN`.
- R11: A `done_pulse` in `ST_PARKED` is ignored. A `done_pulse` in `ST_IDLE`, `ST_RUN` or `ST_IRESUME` sets `err_o`, which stays set until reset.
- R12: Both stall counters, and the stall length itself, saturate at 2^CNT_W-1 rather than wrapping.
- R13: `advance_o` is 0 whenever `tick_en` is low, and `ST_RUN` and `ST_IRESUME` hold their state without it. `ST_IWAIT` and `ST_DWAIT` respond to `done_pulse` regardless of `tick_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Core clock enable for this cycle |
| act_req | input | 1 | Activate the thread |
| susp_req | input | 1 | Suspend, halt or deallocate the thread |
| swout_req | input | 1 | Park the core for handover |
| ic_miss | input | 1 | Instruction fetch missed this cycle |
| ic_evt | input | 1 | Instruction cache will send a completion pulse |
| dc_miss | input | 1 | Data access missed this cycle |
| dc_evt | input | 1 | Data cache will send a completion pulse |
| done_pulse | input | 1 | Outstanding miss has been filled |
| state_o | output | 3 | Current state code |
| advance_o | output | 1 | Core may commit and step this cycle |
| fetch_skip_o | output | 1 | Reuse the held instruction; no interrupt sampling |
| istall_o | output | CNT_W | Total instruction-miss stall cycles |
| dstall_o | output | CNT_W | Total data-miss stall cycles |
| err_o | output | 1 | Sticky flag for an unexpected completion |

## Verification
`advance_o` and `fetch_skip_o` depend on the current state and inputs, so they are due in the same cycle as the stimulus. The bench samples them 1 ns after driving inputs at the falling edge. State, counters and error flag change at the rising edge that follows the stimulus. The bench compares them at the next falling edge against a reference model, which it advances right after that rising edge. A stall of k cycles therefore shows up in its counter at the first falling edge after the edge that saw `done_pulse`.

// File: rtl/miss_stall_pkg.sv
package miss_stall_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_IWAIT   = 3'd2,
        ST_IRESUME = 3'd3,
        ST_DWAIT   = 3'd4,
        ST_PARKED  = 3'd5
    } run_state_e;

    localparam int unsigned NUM_KINDS = 2;
    localparam int unsigned KIND_INSN = 0;
    localparam int unsigned KIND_DATA = 1;

endpackage

// File: rtl/miss_stall_fsm.sv
module miss_stall_fsm
    import miss_stall_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       act_req,
    input  logic       susp_req,
    input  logic       swout_req,
    input  logic       ic_miss,
    input  logic       ic_evt,
    input  logic       dc_miss,
    input  logic       dc_evt,
    input  logic       done_pulse,
    output run_state_e state_q,
    output logic       advance,
    output logic       fetch_skip,
    output logic       span_start,
    output logic       span_step,
    output logic       commit_i,
    output logic       commit_d,
    output logic       err_flag
);

    run_state_e state_d;
    logic       err_q;
    logic       run_go;
    logic       imiss_take;
    logic       dmiss_take;
    logic       stray_done;

    // Qualified miss decisions used by both processes
    assign run_go     = (state_q == ST_RUN) && tick_en && !swout_req && !susp_req;
    assign imiss_take = run_go && ic_miss && ic_evt;
    assign dmiss_take = run_go && !(ic_miss && ic_evt) && dc_miss && dc_evt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_q | stray_done;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (swout_req)    state_d = ST_PARKED;
                else if (act_req) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (swout_req)       state_d = ST_PARKED;
                else if (susp_req)   state_d = ST_IDLE;
                else if (imiss_take) state_d = ST_IWAIT;
                else if (dmiss_take) state_d = ST_DWAIT;
            end
            ST_IWAIT: begin
                if (swout_req)       state_d = ST_PARKED;
                else if (done_pulse) state_d = ST_IRESUME;
            end
            ST_IRESUME: begin
                if (swout_req)    state_d = ST_PARKED;
                else if (tick_en) state_d = ST_RUN;
            end
            ST_DWAIT: begin
                if (swout_req)       state_d = ST_PARKED;
                else if (done_pulse) state_d = ST_RUN;
            end
            ST_PARKED: begin
                if (!swout_req && act_req) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        advance    = 1'b0;
        fetch_skip = 1'b0;
        span_start = 1'b0;
        span_step  = 1'b0;
        commit_i   = 1'b0;
        commit_d   = 1'b0;
        stray_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                stray_done = done_pulse;
            end
            ST_RUN: begin
                stray_done = done_pulse;
                advance    = run_go && !imiss_take;
                span_start = imiss_take || dmiss_take;
            end
            ST_IWAIT: begin
                span_step = !done_pulse;
                commit_i  = done_pulse && !swout_req;
            end
            ST_IRESUME: begin
                stray_done = done_pulse;
                fetch_skip = 1'b1;
                advance    = tick_en && !swout_req;
            end
            ST_DWAIT: begin
                span_step = !done_pulse;
                commit_d  = done_pulse && !swout_req;
            end
            ST_PARKED: begin
                stray_done = 1'b0;
            end
            default: begin
                stray_done = 1'b0;
            end
        endcase
    end

    assign err_flag = err_q;

    // R5
    imiss_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_en && !swout_req && !susp_req && ic_miss && ic_evt)
        |=> (state_q == ST_IWAIT));

    // R9
    resume_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IRESUME && tick_en && !swout_req) |=> (state_q == ST_RUN));

    // R4
    park_on_swout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swout_req |=> (state_q == ST_PARKED));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R11
    parked_done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARKED && done_pulse && !err_flag) |=> !err_flag);

    // R13
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DWAIT && !done_pulse && !swout_req) |=> (state_q == ST_DWAIT));

endmodule

// File: rtl/stall_span_counter.sv
module stall_span_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    output logic [CNT_W-1:0] span
);

    localparam logic [CNT_W-1:0] SPAN_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SPAN_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] span_q;

    // The miss cycle is the first stalled cycle, so a span opens at one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
        end else if (start) begin
            span_q <= SPAN_ONE;
        end else if (step && span_q != SPAN_MAX) begin
            span_q <= span_q + SPAN_ONE;
        end
    end

    assign span = span_q;

    // R12
    span_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && span_q == SPAN_MAX) |=> (span_q == SPAN_MAX));

endmodule

// File: rtl/stall_total_acc.sv
module stall_total_acc #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    output logic [CNT_W-1:0] total
);

    localparam logic [CNT_W-1:0] TOTAL_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] total_q;
    logic [CNT_W:0]   sum_wide;

    assign sum_wide = {1'b0, total_q} + {1'b0, add_val};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (add_en) begin
            total_q <= sum_wide[CNT_W] ? TOTAL_MAX : sum_wide[CNT_W-1:0];
        end
    end

    assign total = total_q;

    // R12
    total_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |=> (total_q >= $past(total_q)));

    // R8
    total_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |=> $stable(total_q));

endmodule

// File: rtl/miss_stall_ctrl.sv
module miss_stall_ctrl
    import miss_stall_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             act_req,
    input  logic             susp_req,
    input  logic             swout_req,
    input  logic             ic_miss,
    input  logic             ic_evt,
    input  logic             dc_miss,
    input  logic             dc_evt,
    input  logic             done_pulse,
    output logic [2:0]       state_o,
    output logic             advance_o,
    output logic             fetch_skip_o,
    output logic [CNT_W-1:0] istall_o,
    output logic [CNT_W-1:0] dstall_o,
    output logic             err_o
);

    run_state_e       state_q;
    logic             span_start;
    logic             span_step;
    logic             commit_i;
    logic             commit_d;
    logic [CNT_W-1:0] span;
    logic [NUM_KINDS-1:0] commit_vec;
    logic [CNT_W-1:0] totals [NUM_KINDS];

    miss_stall_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .act_req    (act_req),
        .susp_req   (susp_req),
        .swout_req  (swout_req),
        .ic_miss    (ic_miss),
        .ic_evt     (ic_evt),
        .dc_miss    (dc_miss),
        .dc_evt     (dc_evt),
        .done_pulse (done_pulse),
        .state_q    (state_q),
        .advance    (advance_o),
        .fetch_skip (fetch_skip_o),
        .span_start (span_start),
        .span_step  (span_step),
        .commit_i   (commit_i),
        .commit_d   (commit_d),
        .err_flag   (err_o)
    );

    // One span counter serves both kinds: only one miss is ever outstanding
    stall_span_counter #(.CNT_W(CNT_W)) u_span (
        .clk   (clk),
        .rst_n (rst_n),
        .start (span_start),
        .step  (span_step),
        .span  (span)
    );

    assign commit_vec[KIND_INSN] = commit_i;
    assign commit_vec[KIND_DATA] = commit_d;

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_acc
        stall_total_acc #(.CNT_W(CNT_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_en  (commit_vec[g]),
            .add_val (span),
            .total   (totals[g])
        );
    end

    assign istall_o = totals[KIND_INSN];
    assign dstall_o = totals[KIND_DATA];
    assign state_o  = state_q;

    // R10
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(commit_vec) <= 1);

endmodule

// File: tb/miss_stall_ctrl_tb_top.sv
`timescale 1ns/1ps
module miss_stall_ctrl_tb_top;

    localparam int unsigned W    = 8;
    localparam int unsigned MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0, act_req = 1'b0, susp_req = 1'b0, swout_req = 1'b0;
    logic ic_miss = 1'b0, ic_evt = 1'b0, dc_miss = 1'b0, dc_evt = 1'b0, done_pulse = 1'b0;
    logic [2:0]   state_o;
    logic         advance_o, fetch_skip_o, err_o;
    logic [W-1:0] istall_o, dstall_o;

    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;

    int          m_st = 0;
    int unsigned m_ela = 0, m_it = 0, m_dt = 0;
    bit          m_err = 1'b0;
    string       m_tag = "R1";

    always #10 clk = ~clk;

    miss_stall_ctrl #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .act_req(act_req),
        .susp_req(susp_req), .swout_req(swout_req), .ic_miss(ic_miss),
        .ic_evt(ic_evt), .dc_miss(dc_miss), .dc_evt(dc_evt),
        .done_pulse(done_pulse), .state_o(state_o), .advance_o(advance_o),
        .fetch_skip_o(fetch_skip_o), .istall_o(istall_o), .dstall_o(dstall_o),
        .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int unsigned act, input int unsigned exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int unsigned sat_add(input int unsigned a, input int unsigned b);
        int unsigned s = a + b;
        return (s > MAXV) ? MAXV : s;
    endfunction

    function automatic bit exp_adv();
        return tick_en && !swout_req &&
               ((m_st == 1 && !susp_req && !(ic_miss && ic_evt)) || m_st == 3);
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0: return "R2";
            1: return "R5";
            2: return "R8";
            3: return "R9";
            4: return "R10";
            default: return "R4";
        endcase
    endfunction

    task automatic model_step();
        bit im = ic_miss && ic_evt;
        bit dm = dc_miss && dc_evt;
        m_tag = tag_of(m_st);
        case (m_st)
            0: begin
                if (done_pulse) m_err = 1'b1;
                if (swout_req) m_st = 5; else if (act_req) m_st = 1;
            end
            1: begin
                if (done_pulse) m_err = 1'b1;
                if (swout_req) m_st = 5;
                else if (susp_req) m_st = 0;
                else if (tick_en && im) begin m_st = 2; m_ela = 1; end
                else if (tick_en && dm) begin m_st = 4; m_ela = 1; end
            end
            2: begin
                if (swout_req) m_st = 5;
                else if (done_pulse) begin m_it = sat_add(m_it, m_ela); m_st = 3; end
                else m_ela = sat_add(m_ela, 1);
            end
            3: begin
                if (done_pulse) m_err = 1'b1;
                if (swout_req) m_st = 5; else if (tick_en) m_st = 1;
            end
            4: begin
                if (swout_req) m_st = 5;
                else if (done_pulse) begin m_dt = sat_add(m_dt, m_ela); m_st = 1; end
                else m_ela = sat_add(m_ela, 1);
            end
            default: begin
                if (!swout_req && act_req) m_st = 1;
            end
        endcase
    endtask

    task automatic check_regs();
        chk(state_o == m_st[2:0], m_tag, "state", state_o, m_st);
        chk(istall_o == m_it, (m_it == MAXV) ? "R12" : "R8", "istall", istall_o, m_it);
        chk(dstall_o == m_dt, (m_dt == MAXV) ? "R12" : "R10", "dstall", dstall_o, m_dt);
        chk(err_o == m_err, "R11", "err", err_o, m_err);
    endtask

    // One cycle: check registered outputs, drive, check combinational ones, clock the model
    task automatic apply(input bit tk, input bit ac, input bit su, input bit sw,
                         input bit im, input bit ie, input bit dmi, input bit de, input bit dn);
        @(negedge clk);
        check_regs();
        tick_en = tk; act_req = ac; susp_req = su; swout_req = sw;
        ic_miss = im; ic_evt = ie; dc_miss = dmi; dc_evt = de; done_pulse = dn;
        #1;
        chk(advance_o == exp_adv(), tk ? "R5" : "R13", "advance", advance_o, exp_adv());
        chk(fetch_skip_o == (m_st == 3), "R9", "fetch_skip", fetch_skip_o, m_st == 3);
        @(posedge clk);
        model_step();
    endtask

    task automatic idle_cycle();
        apply(1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic expect_now(input int s, input string tag);
        #1;
        chk(state_o == s[2:0], tag, "directed state", state_o, s);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_en = 1'b1; act_req = 0; susp_req = 0; swout_req = 0;
        ic_miss = 0; ic_evt = 0; dc_miss = 0; dc_evt = 0; done_pulse = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_ela = 0; m_it = 0; m_dt = 0; m_err = 1'b0; m_tag = "R1";
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        #1;
        chk(state_o == 3'd0, "R1", "reset state", state_o, 0);
        chk(istall_o == 0 && dstall_o == 0, "R1", "reset counters", istall_o, 0);
        chk(err_o == 1'b0, "R1", "reset err", err_o, 0);
        chk(advance_o == 1'b0, "R1", "reset advance", advance_o, 0);

        apply(1, 1, 0, 0, 0, 0, 0, 0, 0); expect_now(1, "R2");
        apply(1, 1, 0, 0, 0, 0, 0, 0, 0); expect_now(1, "R2");
        apply(1, 0, 0, 0, 1, 0, 1, 0, 0); expect_now(1, "R7");
        apply(1, 0, 0, 0, 1, 1, 0, 0, 0); expect_now(2, "R5");
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0); expect_now(2, "R13");
        idle_cycle();
        apply(1, 0, 0, 0, 0, 0, 0, 0, 1); expect_now(3, "R8");
        chk(istall_o == 3, "R8", "three-cycle fetch stall", istall_o, 3);
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0); expect_now(3, "R13");
        apply(1, 0, 0, 0, 0, 0, 0, 0, 0); expect_now(1, "R9");
        apply(1, 0, 0, 0, 0, 0, 1, 1, 0); expect_now(4, "R6");
        apply(1, 0, 0, 0, 0, 0, 0, 0, 1); expect_now(1, "R10");
        chk(dstall_o == 1, "R10", "one-cycle data stall", dstall_o, 1);
        apply(1, 0, 0, 0, 1, 1, 0, 0, 0); expect_now(2, "R5");
        apply(1, 0, 0, 1, 0, 0, 0, 0, 0); expect_now(5, "R4");
        apply(1, 0, 0, 0, 0, 0, 0, 0, 1); expect_now(5, "R11");
        chk(err_o == 1'b0, "R11", "done while parked", err_o, 0);
        apply(1, 1, 0, 0, 0, 0, 0, 0, 0); expect_now(1, "R4");
        apply(1, 0, 1, 0, 0, 0, 0, 0, 0); expect_now(0, "R3");
        apply(1, 0, 1, 0, 0, 0, 0, 0, 0); expect_now(0, "R3");
        apply(1, 1, 0, 0, 0, 0, 0, 0, 0); expect_now(1, "R2");
        apply(1, 0, 0, 0, 1, 1, 0, 0, 0); expect_now(2, "R5");
        for (int i = 0; i < 300; i++) idle_cycle();
        apply(1, 0, 0, 0, 0, 0, 0, 0, 1); expect_now(3, "R12");
        chk(istall_o == MAXV, "R12", "saturated fetch stall", istall_o, MAXV);
        apply(1, 0, 0, 0, 0, 0, 0, 0, 1); expect_now(1, "R11");
        chk(err_o == 1'b1, "R11", "done in resume state", err_o, 1);
        idle_cycle();

        do_reset();
        for (int i = 0; i < 3000; i++) begin
            bit stalled = (m_st == 2 || m_st == 4);
            bit ac = (m_st == 0 || m_st == 5) ? ($urandom % 4 == 0) : ($urandom % 30 == 0);
            bit su = ($urandom % 40 == 0);
            bit sw = ($urandom % 120 == 0);
            bit tk = ($urandom % 8 != 0);
            bit im = ($urandom % 5 == 0);
            bit ie = ($urandom % 4 != 0);
            bit dmi = ($urandom % 5 == 0);
            bit de = ($urandom % 4 != 0);
            bit dn = stalled ? ($urandom % 4 == 0) : ($urandom % 400 == 0);
            apply(tk, ac, su, sw, im, ie, dmi, de, dn);
        end
        idle_cycle();
        @(negedge clk);
        check_regs();

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            nvec++;
            nfail++;
            $display("FAIL R13 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule